// File: doc/BRIEF.md
# Fence-Aware Issue Gate

This gate sits at the rename/issue boundary of an out-of-order core. It takes micro-ops one at a time, in program order, over a valid/ready handshake and decides whether the head micro-op may issue. The decision depends on the micro-op's class. An ALU op or a store always goes through. A load waits while the store buffer asserts its load-block line. A load fence is the only execution barrier: it waits until the reorder buffer is empty and nothing is still in flight in the gate's own issue register. Full fences and store fences do not stall younger work. Each of them issues as one marker-enqueue request to the store buffer, and waits only while that buffer reports full.

Because acceptance is strictly in order, a stalled head holds every younger micro-op behind it. This is what makes the load fence hold back younger ALU work. Younger ALU work still flows straight past a full fence or a store fence once the fence's marker has been enqueued. An accepted micro-op leaves through a registered issue port on the next cycle. Reorder-buffer occupancy, load blocking and store-buffer fullness come from neighbouring logic as plain inputs.

Top module: `fence_issue_gate`

## Requirements
- R1: Class codes on uop_class_i are ALU=0, load=1, store=2, load fence=3, full fence=4, store fence=5. For ALU and store micro-ops, uop_ready_o is high in every cycle after reset, whatever the other inputs are.
- R2: For a load micro-op, uop_ready_o equals the inverse of ld_block_i.
- R3: For a load fence, uop_ready_o is high only when rob_count_i is zero and issue_valid_o is low in that cycle.
- R4: For a full fence or a store fence, uop_ready_o equals the inverse of sb_full_i.
- R5: The reserved class codes 6 and 7 are never accepted: uop_ready_o stays low for them and nothing issues.
- R6: A micro-op is accepted when uop_valid_i and uop_ready_o are both high at a clock edge. In the next cycle issue_valid_o is high and issue_class_o carries its class. In every other cycle issue_valid_o is low, so at most one micro-op issues per cycle.
- R7: mark_req_o is high for exactly the cycle in which a full fence or a store fence issues, and never otherwise. mark_full_o is 1 for a full-fence marker and 0 for a store-fence marker.
- R8: While rst_ni is low, issue_valid_o, issue_class_o, mark_req_o and mark_full_o are all zero.
- R9: An ALU op that follows a full fence issues in the cycle right after the fence, even while the reorder buffer is non-empty. An ALU op that follows a load fence issues only after rob_count_i has reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uop_valid_i | input | 1 | Head micro-op present |
| uop_class_i | input | 3 | Head micro-op class code |
| uop_ready_o | output | 1 | Head micro-op may be accepted this cycle |
| rob_count_i | input | ROB_CNT_W (7) | Reorder-buffer occupancy |
| ld_block_i | input | 1 | Store buffer blocks load issue |
| sb_full_i | input | 1 | Store buffer cannot take a marker |
| issue_valid_o | output | 1 | Micro-op issued this cycle |
| issue_class_o | output | 3 | Class of the issued micro-op |
| mark_req_o | output | 1 | Marker-enqueue request to the store buffer |
| mark_full_o | output | 1 | Marker kind: 1 full fence, 0 store fence |

## Verification
The hardest case to reach is a load fence that arrives right behind a micro-op still sitting in the issue register. At that moment rob_count_i already reads zero, but the gate must still refuse the fence for one more cycle. Random stimulus drives rob_count_i to zero with raised probability and puts fences into the class stream often, so this back-to-back case occurs many times. Directed sequences add the full-fence and load-fence orderings with a busy reorder buffer.

// File: rtl/fig_pkg.sv
package fig_pkg;
  typedef enum logic [2:0] {
    UC_ALU    = 3'd0,
    UC_LOAD   = 3'd1,
    UC_STORE  = 3'd2,
    UC_LFENCE = 3'd3,
    UC_FULLF  = 3'd4,
    UC_STOREF = 3'd5
  } uop_class_e;

  localparam int unsigned CLS_W = 3;
endpackage

// File: rtl/fig_policy.sv
module fig_policy
  import fig_pkg::*;
#(
  parameter int unsigned ROB_CNT_W = 7
) (
  input  logic [CLS_W-1:0]     cls_i,
  input  logic [ROB_CNT_W-1:0] rob_count_i,
  input  logic                 inflight_i,
  input  logic                 ld_block_i,
  input  logic                 sb_full_i,
  output logic                 ok_o,
  output logic                 mark_o,
  output logic                 mark_full_o
);
  logic rob_empty;
  assign rob_empty = (rob_count_i == '0);

  always_comb begin
    ok_o        = 1'b0;
    mark_o      = 1'b0;
    mark_full_o = 1'b0;
    case (cls_i)
      UC_ALU, UC_STORE: ok_o = 1'b1;
      UC_LOAD:          ok_o = ~ld_block_i;
      // issue register not yet visible in the ROB count
      UC_LFENCE:        ok_o = rob_empty & ~inflight_i;
      UC_FULLF: begin
        ok_o        = ~sb_full_i;
        mark_o      = 1'b1;
        mark_full_o = 1'b1;
      end
      UC_STOREF: begin
        ok_o   = ~sb_full_i;
        mark_o = 1'b1;
      end
      default:          ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fig_issue_reg.sv
module fig_issue_reg
  import fig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [CLS_W-1:0] cls_i,
  input  logic             mark_i,
  input  logic             mark_full_i,
  output logic             valid_o,
  output logic [CLS_W-1:0] cls_o,
  output logic             mark_o,
  output logic             mark_full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      cls_o       <= '0;
      mark_o      <= 1'b0;
      mark_full_o <= 1'b0;
    end else begin
      valid_o     <= take_i;
      cls_o       <= take_i ? cls_i : '0;
      mark_o      <= take_i & mark_i;
      mark_full_o <= take_i & mark_i & mark_full_i;
    end
  end
endmodule

// File: rtl/fence_issue_gate.sv
module fence_issue_gate
  import fig_pkg::*;
#(
  parameter int unsigned ROB_DEPTH = 64,
  localparam int unsigned ROB_CNT_W = $clog2(ROB_DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 uop_valid_i,
  input  logic [CLS_W-1:0]     uop_class_i,
  output logic                 uop_ready_o,
  input  logic [ROB_CNT_W-1:0] rob_count_i,
  input  logic                 ld_block_i,
  input  logic                 sb_full_i,
  output logic                 issue_valid_o,
  output logic [CLS_W-1:0]     issue_class_o,
  output logic                 mark_req_o,
  output logic                 mark_full_o
);
  logic ok, mark, mark_full, take;

  fig_policy #(.ROB_CNT_W(ROB_CNT_W)) u_policy (
    .cls_i      (uop_class_i),
    .rob_count_i(rob_count_i),
    .inflight_i (issue_valid_o),
    .ld_block_i (ld_block_i),
    .sb_full_i  (sb_full_i),
    .ok_o       (ok),
    .mark_o     (mark),
    .mark_full_o(mark_full)
  );

  assign uop_ready_o = ok;
  assign take        = uop_valid_i & ok;

  fig_issue_reg u_ireg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .cls_i      (uop_class_i),
    .mark_i     (mark),
    .mark_full_i(mark_full),
    .valid_o    (issue_valid_o),
    .cls_o      (issue_class_o),
    .mark_o     (mark_req_o),
    .mark_full_o(mark_full_o)
  );

  AST_LFENCE_DRAINED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && issue_class_o == UC_LFENCE |-> $past(rob_count_i == '0) && !$past(issue_valid_o)); // R3
  AST_LOAD_UNBLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && issue_class_o == UC_LOAD |-> !$past(ld_block_i)); // R2
  AST_MARK_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_req_o |-> !$past(sb_full_i)); // R4
  AST_MARK_ONLY_FENCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_req_o == (issue_valid_o && (issue_class_o == UC_FULLF || issue_class_o == UC_STOREF))); // R7
  AST_NO_RESERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> issue_class_o <= 3'd5); // R5
  AST_ISSUE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_valid_i && uop_ready_o |=> issue_valid_o && issue_class_o == $past(uop_class_i)); // R6
endmodule

// File: tb/fence_issue_gate_test.sv
`timescale 1ns/1ps
module fence_issue_gate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0;
  logic [2:0] cls = '0;
  logic [6:0] rob = '0;
  logic blk = 1'b0, full = 1'b0;
  logic rdy, iv, mrq, mfl;
  logic [2:0] icl;
  int n_chk = 0, n_fail = 0;
  logic e_iv = 1'b0, e_mrq = 1'b0, e_mfl = 1'b0;
  logic [2:0] e_icl = '0;

  always #2.5 clk = ~clk;

  fence_issue_gate uut (
    .clk_i(clk), .rst_ni(rst_n), .uop_valid_i(vld), .uop_class_i(cls),
    .uop_ready_o(rdy), .rob_count_i(rob), .ld_block_i(blk), .sb_full_i(full),
    .issue_valid_o(iv), .issue_class_o(icl), .mark_req_o(mrq), .mark_full_o(mfl)
  );

  function automatic logic exp_ready(input logic [2:0] c, input logic [6:0] r,
                                     input logic b, input logic f, input logic inflight);
    case (c)
      3'd0, 3'd2: return 1'b1;
      3'd1:       return ~b;
      3'd3:       return (r == 0) && !inflight;
      3'd4, 3'd5: return ~f;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0, 3'd2: return "R1";
      3'd1:       return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R5";
    endcase
  endfunction

  // one cycle: check registered outputs, drive, check ready, advance model
  task automatic step(input logic v, input logic [2:0] c, input logic [6:0] r,
                      input logic b, input logic f);
    logic er, acc;
    @(negedge clk);
    chk("R6", {7'd0, iv}, {7'd0, e_iv});
    if (e_iv) chk("R6", {5'd0, icl}, {5'd0, e_icl});
    chk("R7", {6'd0, mrq, mfl}, {6'd0, e_mrq, e_mfl});
    vld = v; cls = c; rob = r; blk = b; full = f;
    #1;
    er = exp_ready(c, r, b, f, e_iv);
    chk(req_of(c), {7'd0, rdy}, {7'd0, er});
    acc   = v && er;
    e_iv  = acc;
    e_icl = acc ? c : 3'd0;
    e_mrq = acc && (c == 3'd4 || c == 3'd5);
    e_mfl = acc && (c == 3'd4);
  endtask

  initial begin
    #100000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R8", {4'd0, iv, mrq, mfl, 1'b0}, 8'd0);
    chk("R8", {5'd0, icl}, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    // R9: full fence then ALU with busy ROB
    step(1, 3'd4, 7'd20, 0, 0);
    step(1, 3'd0, 7'd20, 0, 0);
    chk("R9", {7'd0, rdy}, 8'd1);
    // R9: load fence held until ROB drains, ALU waits behind it
    step(1, 3'd3, 7'd5, 0, 0);
    chk("R9", {7'd0, rdy}, 8'd0);
    step(1, 3'd3, 7'd2, 0, 0);
    step(1, 3'd3, 7'd0, 0, 0);
    chk("R9", {7'd0, rdy}, 8'd1);
    step(1, 3'd0, 7'd9, 0, 0);
    // R3: load fence right behind an issued op with ROB already zero
    step(1, 3'd0, 7'd0, 0, 0);
    step(1, 3'd3, 7'd0, 0, 0);
    chk("R3", {7'd0, rdy}, 8'd0);
    step(1, 3'd3, 7'd0, 0, 0);
    // R4, R2, R5 corners
    step(1, 3'd5, 7'd3, 1, 1);
    step(1, 3'd5, 7'd3, 1, 0);
    step(1, 3'd1, 7'd3, 1, 0);
    step(1, 3'd1, 7'd3, 0, 1);
    step(1, 3'd6, 7'd0, 0, 0);
    step(1, 3'd7, 7'd0, 0, 0);
    step(0, 3'd0, 7'd0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [6:0] r;
      r = ($urandom % 3 == 0) ? 7'd0 : 7'($urandom % 65);
      step(1'($urandom % 5 != 0), 3'($urandom % 8), r,
           1'($urandom % 3 == 0), 1'($urandom % 4 == 0));
    end
    step(0, 3'd0, 7'd0, 0, 0);
    step(0, 3'd0, 7'd0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule